// File: doc/BRIEF.md
# Programmable Device-Bus Timing Sequencer

This block runs read and write accesses to an 8-bit flash or SRAM over a bus that carries the address and the data on the same wires. The host hands over one request: start address, direction, beat count and first write byte. The sequencer then plays out the whole access on the device pins. Every phase length is a count of clock cycles taken from a 32-bit timing register. The phases are the address-latch strobe, the wait for the first read sample, the spacing of later samples, the delay to the write strobe, the write strobe low and high times, the address-to-sample skew and the bus release after a read.

Each phase count is a short field with its own extension bit above it. That bit is the count's most significant bit, so a 3-bit field reaches 15 and the 4-bit first-sample field reaches 31. A field value of zero counts as one cycle. The register comes out of reset with slow, safe timing and can be rewritten for faster parts. The timing in force is captured when a request is accepted. The device data pins appear as separate out, enable and in signals, ready for a pad cell.

Top module: `devbus_seq`

## Requirements
- R1: The timing register `cfg_rdata` resets to 0x8FCFFFFF. A cycle with `cfg_we` high loads `cfg_wdata` at the closing edge, and `cfg_rdata` shows the stored value.
- R2: Field layout (raw value; extension bit is the top bit of each slot): first-sample wait F = bits [4:0]; next-sample spacing N = [8:5]; latch-to-write delay W = [12:9]; write-low time L = [16:13]; write-high time H = [20:17]; bus-release gap T = [24:21]; address skew S = [26:25]. Setting only an extension bit gives 16 for the 5-bit field and 8 for a 4-bit slot.
- R3: Any of F, N, W, L, H, T, S that is zero acts as one cycle.
- R4: With `req_ready` high, a cycle with `req_valid` high accepts the request. The next cycle (cycle 0) is the only one with `ale` high. In cycle 0, `badr` equals `req_addr`, `dq_oe` is high and `dq_out` carries `req_addr[7:0]`. `req_ready` is high only when no access is in progress.
- R5: Read: `rd_stb` is high from cycle 1 through the last sample cycle, and `dq_oe` stays low. Beat 0 is sampled from `dq_in` at the end of cycle F. Each sampled byte appears on `rd_data` with `rd_valid` high for one cycle, in the cycle after the sample.
- R6: Read burst: beat k is sampled at the end of cycle F + k·P, where P = max(N, S). `badr` steps by one in the cycle after each sample except the last, and the step carries across all address bits.
- R7: After the last read sample at the end of cycle Z, cycles Z+1 to Z+T have `rd_stb`, `dq_oe` and `req_ready` low. `req_ready` is high in cycle Z+T+1.
- R8: Write: `dq_oe` is high from cycle 0 to the end of the last strobe. For beat k, `wr_stb` is high in cycles W+k·(L+H) to W+k·(L+H)+L−1, and it is low for H cycles between beats.
- R9: Write data and address: beat 0 drives the `req_wdata` captured at acceptance. Beat k ≥ 1 changes `badr` and `dq_out` at the start of cycle W+k·(L+H)−1, so the old values stay for H−1 high cycles. `wd_pop` is high in the cycle just before that change, and `req_wdata` is taken at the end of that cycle. `req_ready` is high the cycle after the last strobe cycle.
- R10: `req_len` holds the beat count minus one. A burst has exactly `req_len`+1 samples or strobes.
- R11: Timing is captured at acceptance. Writing the register during an access leaves that access unchanged and applies from the next one.
- R12: Bits [28:27] (device width, 00 = 8-bit), bit 29 (parity enable, 0 = off) and bits [31:30] are stored and read back, and they have no effect on timing.
- R13: At most one of `ale`, `rd_stb` and `wr_stb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| cfg_we | input | 1 | Timing register write enable |
| cfg_wdata | input | 32 | Timing register write value |
| cfg_rdata | output | 32 | Timing register contents |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | AW | Start address |
| req_len | input | LW | Beats minus one |
| req_wdata | input | 8 | Write byte for the current or next beat |
| wd_pop | output | 1 | `req_wdata` taken at the end of this cycle |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | `rd_data` valid |
| ale | output | 1 | Address latch strobe |
| badr | output | AW | Latched address bus |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |
| dq_out | output | 8 | Device data out |
| dq_oe | output | 1 | Device data drive enable |
| dq_in | input | 8 | Device data in |

## Verification
The bound checker enforces the cycle-level rules on every cycle. The three strobes are mutually exclusive. Nothing is driven while the read strobe is high. The write strobe always comes with a driven bus. Latch and request acceptance follow each other. The bus is released and not ready right after a read ends. Address and data hold steady while the write strobe is low. The absolute phase positions cannot be shown that way, because each depends on the captured field values, the beat index and the zero-as-one rule. These are the exact cycle of each sample, the spacing rule max(N, S), the bus-release length, the point in the high time where the next beat's data appears, and whether a mid-access register write is ignored. The bench shows them by sweeping small field values and burst lengths and checking every output in every cycle against positions it computes itself.

// File: rtl/devbus_pkg.sv
package devbus_pkg;

  localparam int CFG_W     = 32;
  localparam int SLOT_W    = 4;
  localparam int N_SLOTS   = 5;
  localparam int FIRST_W   = 5;
  localparam int SLOT0_LSB = FIRST_W;
  localparam int SKEW_LSB  = SLOT0_LSB + SLOT_W * N_SLOTS;
  localparam int CNT_W     = FIRST_W;

  // slot indices inside the packed slot area
  localparam int SL_NEXT = 0;
  localparam int SL_A2W  = 1;
  localparam int SL_WLO  = 2;
  localparam int SL_WHI  = 3;
  localparam int SL_TOFF = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ALE   = 3'd1,
    ST_RWAIT = 3'd2,
    ST_WSET  = 3'd3,
    ST_WLO   = 3'd4,
    ST_WHI   = 3'd5,
    ST_GAP   = 3'd6
  } seq_state_e;

  // effective (never zero) phase lengths
  typedef struct packed {
    logic [FIRST_W-1:0] first;
    logic [SLOT_W-1:0]  period;
    logic [SLOT_W-1:0]  a2w;
    logic [SLOT_W-1:0]  wlo;
    logic [SLOT_W-1:0]  whi;
    logic [SLOT_W-1:0]  toff;
  } timing_t;

  function automatic logic [SLOT_W-1:0] clamp_slot(input logic [SLOT_W-1:0] v);
    return (v == '0) ? SLOT_W'(1) : v;
  endfunction

  function automatic logic [FIRST_W-1:0] clamp_first(input logic [FIRST_W-1:0] v);
    return (v == '0) ? FIRST_W'(1) : v;
  endfunction

endpackage

// File: rtl/devbus_cfg.sv
module devbus_cfg
  import devbus_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_VAL = 32'h8FCF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output timing_t          timing
);

  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic [SLOT_W-1:0] slot_eff [N_SLOTS];
  logic [SLOT_W-1:0] skew_eff;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= RESET_VAL;
    else        cfg_q <= cfg_d;
  end

  assign rdata = cfg_q;

  for (genvar gi = 0; gi < N_SLOTS; gi++) begin : g_slot
    assign slot_eff[gi] = clamp_slot(cfg_q[SLOT0_LSB + SLOT_W*gi +: SLOT_W]);
  end

  assign skew_eff = (cfg_q[SKEW_LSB +: 2] == 2'd0) ? SLOT_W'(1)
                                                   : {{(SLOT_W-2){1'b0}}, cfg_q[SKEW_LSB +: 2]};

  always_comb begin
    timing.first  = clamp_first(cfg_q[FIRST_W-1:0]);
    timing.period = (slot_eff[SL_NEXT] > skew_eff) ? slot_eff[SL_NEXT] : skew_eff;
    timing.a2w    = slot_eff[SL_A2W];
    timing.wlo    = slot_eff[SL_WLO];
    timing.whi    = slot_eff[SL_WHI];
    timing.toff   = slot_eff[SL_TOFF];
  end

endmodule

// File: rtl/devbus_phase_cnt.sv
module devbus_phase_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - W'(1);
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/devbus_seq_fsm.sv
module devbus_seq_fsm
  import devbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 3,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  timing_t          timing_in,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [LW-1:0]    req_len,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             wd_pop,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             ale,
  output logic [AW-1:0]    badr,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid
);

  localparam int PAD = CNT_W - SLOT_W;

  seq_state_e    st_q, st_d;
  timing_t       tim_q, tim_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wd_q, wd_d;
  logic [LW-1:0] beat_q, beat_d;
  logic [LW-1:0] len_q, len_d;
  logic          wr_q, wr_d;
  logic [DW-1:0] rdd_q, rdd_d;
  logic          rdv_q, rdv_d;
  logic          adv;
  logic          last_beat;
  logic          cnt_zero, cnt_one;

  assign last_beat = (beat_q == len_q);
  assign cnt_zero  = (cnt == '0);
  assign cnt_one   = (cnt == CNT_W'(1));

  always_comb begin
    st_d     = st_q;
    tim_d    = tim_q;
    addr_d   = addr_q;
    wd_d     = wd_q;
    beat_d   = beat_q;
    len_d    = len_q;
    wr_d     = wr_q;
    rdd_d    = rdd_q;
    rdv_d    = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    adv      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d   = ST_ALE;
          tim_d  = timing_in;
          addr_d = req_addr;
          wd_d   = req_wdata;
          len_d  = req_len;
          beat_d = '0;
          wr_d   = req_write;
        end
      end
      ST_ALE: begin
        cnt_load = 1'b1;
        if (!wr_q) begin
          st_d    = ST_RWAIT;
          cnt_val = tim_q.first - CNT_W'(1);
        end else if (tim_q.a2w == SLOT_W'(1)) begin
          st_d    = ST_WLO;
          cnt_val = {{PAD{1'b0}}, tim_q.wlo} - CNT_W'(1);
        end else begin
          st_d    = ST_WSET;
          cnt_val = {{PAD{1'b0}}, tim_q.a2w} - CNT_W'(2);
        end
      end
      ST_RWAIT: begin
        if (cnt_zero) begin
          rdv_d    = 1'b1;
          rdd_d    = dq_in;
          cnt_load = 1'b1;
          if (last_beat) begin
            st_d    = ST_GAP;
            cnt_val = {{PAD{1'b0}}, tim_q.toff} - CNT_W'(1);
          end else begin
            adv     = 1'b1;
            cnt_val = {{PAD{1'b0}}, tim_q.period} - CNT_W'(1);
          end
        end
      end
      ST_WSET: begin
        if (cnt_zero) begin
          st_d     = ST_WLO;
          cnt_load = 1'b1;
          cnt_val  = {{PAD{1'b0}}, tim_q.wlo} - CNT_W'(1);
        end
      end
      ST_WLO: begin
        if (cnt_zero) begin
          if (last_beat) begin
            st_d = ST_IDLE;
          end else begin
            st_d     = ST_WHI;
            cnt_load = 1'b1;
            cnt_val  = {{PAD{1'b0}}, tim_q.whi} - CNT_W'(1);
            adv      = (tim_q.whi == SLOT_W'(1));
          end
        end
      end
      ST_WHI: begin
        if (cnt_one) adv = 1'b1;
        if (cnt_zero) begin
          st_d     = ST_WLO;
          cnt_load = 1'b1;
          cnt_val  = {{PAD{1'b0}}, tim_q.wlo} - CNT_W'(1);
        end
      end
      ST_GAP: begin
        if (cnt_zero) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (adv) begin
      addr_d = addr_q + AW'(1);
      beat_d = beat_q + LW'(1);
      if (wr_q) wd_d = req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tim_q  <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      beat_q <= '0;
      len_q  <= '0;
      wr_q   <= 1'b0;
      rdd_q  <= '0;
      rdv_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tim_q  <= tim_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      beat_q <= beat_d;
      len_q  <= len_d;
      wr_q   <= wr_d;
      rdd_q  <= rdd_d;
      rdv_q  <= rdv_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign wd_pop    = adv & wr_q;
  assign ale       = (st_q == ST_ALE);
  assign rd_stb    = (st_q == ST_RWAIT);
  assign wr_stb    = (st_q == ST_WLO);
  assign dq_oe     = (st_q == ST_ALE) | (st_q == ST_WSET) | (st_q == ST_WLO) | (st_q == ST_WHI);
  assign dq_out    = (st_q == ST_ALE) ? addr_q[DW-1:0] : wd_q;
  assign badr      = addr_q;
  assign rd_data   = rdd_q;
  assign rd_valid  = rdv_q;

endmodule

// File: rtl/devbus_seq.sv
module devbus_seq
  import devbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 3,
  parameter int DW = 8,
  parameter logic [31:0] RESET_CFG = 32'h8FCF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic [DW-1:0] req_wdata,
  output logic          wd_pop,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          ale,
  output logic [AW-1:0] badr,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in
);

  logic [1:0]       rsync_q, rsync_d;
  logic             rst_n_i;
  timing_t          timing;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val, cnt;

  always_comb rsync_d = {rsync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= rsync_d;
  end

  assign rst_n_i = rsync_q[1];

  devbus_cfg #(.RESET_VAL(RESET_CFG)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .timing (timing)
  );

  devbus_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (cnt_load),
    .load_val (cnt_val),
    .cnt      (cnt)
  );

  devbus_seq_fsm #(.AW(AW), .LW(LW), .DW(DW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .timing_in (timing),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .wd_pop    (wd_pop),
    .cnt       (cnt),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .ale       (ale),
    .badr      (badr),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .dq_in     (dq_in),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

endmodule

// File: rtl/devbus_seq_chk.sv
module devbus_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          ale,
  input logic          rd_stb,
  input logic          wr_stb,
  input logic          dq_oe,
  input logic          rd_valid,
  input logic [AW-1:0] badr,
  input logic [DW-1:0] dq_out
);

  p_one_phase_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ale, rd_stb, wr_stb}));

  p_read_undriven_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> !dq_oe);

  p_write_driven_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> dq_oe);

  p_accept_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (ale && dq_oe));

  p_latch_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  p_busy_not_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ale || rd_stb || wr_stb) |-> !req_ready);

  p_release_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_stb) |-> (!dq_oe && !req_ready));

  p_write_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && $past(wr_stb)) |-> ($stable(badr) && $stable(dq_out)));

  p_valid_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_stb));

endmodule

bind devbus_seq devbus_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ale       (ale),
  .rd_stb    (rd_stb),
  .wr_stb    (wr_stb),
  .dq_oe     (dq_oe),
  .rd_valid  (rd_valid),
  .badr      (badr),
  .dq_out    (dq_out)
);

// File: tb/sim_devbus_seq.sv
module sim_devbus_seq;

  localparam int AW = 16;
  localparam int LW = 3;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          wd_pop;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          ale;
  logic [AW-1:0] badr;
  logic          rd_stb;
  logic          wr_stb;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  logic [DW-1:0] dq_in = '0;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  devbus_seq #(.AW(AW), .LW(LW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_len(req_len), .req_wdata(req_wdata), .wd_pop(wd_pop), .rd_data(rd_data),
    .rd_valid(rd_valid), .ale(ale), .badr(badr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // R2 layout: F[4:0] N[8:5] W[12:9] L[16:13] H[20:17] T[24:21] S[26:25] misc[31:27]
  function automatic logic [31:0] mk(input int f, input int nx, input int w, input int l,
                                      input int h, input int t, input int s, input int misc);
    logic [31:0] v;
    v = 32'(f & 31) | (32'(nx & 15) << 5) | (32'(w & 15) << 9) | (32'(l & 15) << 13)
      | (32'(h & 15) << 17) | (32'(t & 15) << 21) | (32'(s & 3) << 25) | (32'(misc & 31) << 27);
    return v;
  endfunction

  function automatic logic [7:0] wdat(input logic [15:0] a, input int k);
    return 8'(a[7:0] + 8'h31 + k * 13);
  endfunction

  task automatic cfg_write(input logic [31:0] v);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R1 cfg readback", cfg_rdata, v);
  endtask

  // one access; c timing, c2 written in cycle 2 when mid is set (R11)
  task automatic run(input logic [31:0] c, input bit wr, input logic [15:0] a, input int n,
                     input bit mid, input logic [31:0] c2);
    int f, p, t, w, l, h, z, endc, pops;
    f = eff(int'(c[4:0]));
    p = eff(int'(c[8:5]));
    if (eff(int'(c[26:25])) > p) p = eff(int'(c[26:25]));
    w = eff(int'(c[12:9]));
    l = eff(int'(c[16:13]));
    h = eff(int'(c[20:17]));
    t = eff(int'(c[24:21]));
    z = wr ? (w + (n-1)*(l+h) + l - 1) : (f + (n-1)*p);
    endc = wr ? z + 1 : z + t + 1;
    pops = 0;
    chk("R4 ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_len   = LW'(n - 1);
    req_wdata = wdat(a, 0);
    @(negedge clk);
    req_valid = 1'b0;
    for (int cy = 0; cy <= endc; cy++) begin
      bit e_rd, e_wr, e_oe, e_rdy, e_rv, e_pop;
      int k, rk;
      if (cy > 0) @(negedge clk);
      dq_in = badr[7:0] ^ 8'h5A;
      if (mid && cy == 2) begin cfg_we = 1'b1; cfg_wdata = c2; end
      if (mid && cy == 3) cfg_we = 1'b0;
      e_pop = 1'b0; e_rv = 1'b0; rk = 0;
      if (!wr) begin
        e_rd  = (cy >= 1) && (cy <= z);
        e_wr  = 1'b0;
        e_oe  = (cy == 0);
        e_rdy = (cy == endc);
        k = (cy <= f) ? 0 : ((cy - f - 1) / p + 1);
        if (k > n - 1) k = n - 1;
        if (cy >= f + 1) begin
          rk = (cy - f - 1) / p;
          e_rv = ((cy - f - 1) % p == 0) && (rk <= n - 1);
        end
      end else begin
        e_rd  = 1'b0;
        e_wr  = (cy >= w) && (cy <= z) && (((cy - w) % (l + h)) < l);
        e_oe  = (cy <= z);
        e_rdy = (cy == z + 1);
        k = 0;
        for (int j = 1; j < n; j++) begin
          if (cy >= w + j*(l+h) - 1) k = j;
          if (cy == w + j*(l+h) - 2) e_pop = 1'b1;
        end
      end
      chk("R4 ale", ale, (cy == 0));
      chk("R5 rd_stb", rd_stb, e_rd);
      chk("R8 wr_stb", wr_stb, e_wr);
      chk("R7 dq_oe", dq_oe, e_oe);
      chk("R7 req_ready", req_ready, e_rdy);
      chk("R6 badr", badr, 32'(16'(a + k)));
      if (e_oe) chk("R9 dq_out", dq_out, (cy == 0) ? a[7:0] : wdat(a, k));
      chk("R5 rd_valid", rd_valid, e_rv);
      if (e_rv) chk("R6 rd_data", rd_data, 32'(8'(a + rk) ^ 8'h5A));
      chk("R9 wd_pop", wd_pop, e_pop);
      if (wd_pop === 1'b1) begin
        req_wdata = wdat(a, pops + 1);
        pops++;
      end
    end
    chk("R10 beat count", wr ? pops + 1 : n, n);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int fa[3] = '{1, 2, 4};
    int na[3] = '{1, 2, 3};
    int idx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    chk("R1 reset value", cfg_rdata, 32'h8FCF_FFFF);
    chk("R4 reset ready", req_ready, 1);
    chk("R13 reset strobes", {ale, rd_stb, wr_stb, dq_oe, rd_valid}, 0);
    // slow reset timing
    run(32'h8FCF_FFFF, 1'b0, 16'h0100, 2, 1'b0, 0);
    run(32'h8FCF_FFFF, 1'b1, 16'h0200, 2, 1'b0, 0);
    // R3 zero fields behave as one
    cfg_write(32'h0);
    run(32'h0, 1'b0, 16'h30FE, 3, 1'b0, 0);
    run(32'h0, 1'b1, 16'h31FF, 3, 1'b0, 0);
    // R2 extension bits
    cfg_write(mk(5'b10010, 4'b1000, 4'b1001, 4'b1010, 4'b1000, 4'b1000, 0, 0));
    run(mk(5'b10010, 4'b1000, 4'b1001, 4'b1010, 4'b1000, 4'b1000, 0, 0), 1'b0, 16'h4000, 2, 1'b0, 0);
    run(mk(5'b10010, 4'b1000, 4'b1001, 4'b1010, 4'b1000, 4'b1000, 0, 0), 1'b1, 16'h4100, 2, 1'b0, 0);
    // R12 width/parity/reserved bits have no effect
    cfg_write(mk(2, 2, 2, 1, 2, 2, 1, 5'b11111));
    run(mk(2, 2, 2, 1, 2, 2, 1, 5'b11111), 1'b0, 16'h5000, 2, 1'b0, 0);
    run(mk(2, 2, 2, 1, 2, 2, 1, 5'b11111), 1'b1, 16'h5100, 2, 1'b0, 0);
    // R11 register write during an access
    cfg_write(mk(3, 2, 1, 1, 1, 2, 1, 0));
    run(mk(3, 2, 1, 1, 1, 2, 1, 0), 1'b0, 16'h6000, 3, 1'b1, mk(1, 1, 2, 2, 2, 1, 1, 0));
    chk("R11 new value stored", cfg_rdata, mk(1, 1, 2, 2, 2, 1, 1, 0));
    run(mk(1, 1, 2, 2, 2, 1, 1, 0), 1'b1, 16'h6100, 2, 1'b0, 0);
    // read sweep R5 R6 R7
    idx = 0;
    foreach (fa[i]) for (int nx = 1; nx <= 3; nx++) for (int s = 1; s <= 3; s += 2)
      for (int t = 1; t <= 3; t += 2) for (int nb = 1; nb <= 3; nb += 2) begin
        logic [31:0] c;
        c = mk(fa[i], nx, 1, 1, 1, t, s, 0);
        cfg_write(c);
        run(c, 1'b0, 16'h12FE + 16'(idx), nb, 1'b0, 0);
        idx++;
      end
    // write sweep R8 R9 R10
    foreach (na[i]) for (int l = 1; l <= 2; l++) for (int h = 1; h <= 3; h++)
      for (int nb = 1; nb <= 3; nb += 2) begin
        logic [31:0] c;
        c = mk(1, 1, na[i], l, h, 1, 1, 0);
        cfg_write(c);
        run(c, 1'b1, 16'h23FE + 16'(idx), nb, 1'b0, 0);
        idx++;
      end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule